// File: doc/BRIEF.md
# Decimal Command Line Parser

This block turns a stream of received characters into control commands for a signal generator. The operator types a base-ten number followed by a single command letter. The block builds the number one digit at a time into an unsigned register. When the letter arrives, it issues a frequency, phase or amplitude command that carries the number.

Every character the block recognises is sent back through the transmit side so that a terminal shows what was typed. A carriage return is expanded into a return followed by a line feed. The receiver and the transmitter are reduced to simple handshakes:

- On the receive side, a one-cycle valid pulse carries each byte.
- On the transmit side, a busy flag is returned.

The consumer of the commands may run much more slowly than this block. For that reason, a command stays posted until the consumer acknowledges it.

At a 25 MHz clock, the intended serial rate is 1200 baud, which is 20833 clocks per bit. At that rate, pasted lines are echoed without losing characters.

Top module: `dec_cmd_parser`

## Requirements
- R1: After reset, `cmd_code` is 0, `tx_valid` is low, the held number is 0 and the digit count is cleared.
- R2: Bytes 0x30 to 0x39 are digits. The first digit after the count was cleared loads the number directly. Each later digit makes number = number*10 + digit.
- R3: The byte 0x66 posts code 1 (frequency), 0x70 posts code 2 (phase) and 0x61 posts code 3 (amplitude). The command carries the current number and appears one cycle after the letter's `rx_valid`. Each letter clears the digit count.
- R4: The byte 0x0D clears the digit count and posts no command.
- R5: Every digit, command letter or 0x0D is echoed unchanged as a one-cycle `tx_valid` pulse in the cycle after its `rx_valid`, whatever the state of `tx_busy`.
- R6: Any other byte produces no echo and leaves the number and the digit count untouched.
- R7: After a 0x0D echo, one 0x0A is sent. It is sent only after a cycle in which `tx_busy` was low, and never while `tx_busy` is high.
- R8: A posted `cmd_code` and `cmd_value` stay unchanged until `cmd_ack` is seen high. In the cycle after that, `cmd_code` is 0.
- R9: For an amplitude command, `cmd_value` holds only the low AMP_W bits of the number; the upper bits are zero.
- R10: The number accumulates modulo 2^VALUE_W, with no error indication.
- R11: A letter that has no digits before it posts the number last held.
- R12: A new letter replaces a command still posted, even in a cycle where `cmd_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a received character |
| rx_byte | input | 8 | Received character |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_valid | output | 1 | One-cycle request to send `tx_byte` |
| tx_byte | output | 8 | Character to send |
| cmd_code | output | 2 | Posted command: 0 none, 1 frequency, 2 phase, 3 amplitude |
| cmd_value | output | VALUE_W | Number carried by the posted command |
| cmd_ack | input | 1 | Consumer has taken the posted command |

## Verification
The bench builds the parser with its default widths: a 32-bit number and a 16-bit amplitude field. With those widths, a ten-digit entry is enough to force the modulo-2^32 wrap, and a five-digit amplitude above 65535 shows the upper bits being dropped. A short transmitter model keeps `tx_busy` high for a few cycles after each send. This makes the deferred line feed observable, and it lets back-to-back characters arrive while the transmitter is still busy.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_FREQ  = 2'd1,
    CMD_PHASE = 2'd2,
    CMD_AMPL  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    BK_OTHER,
    BK_DIGIT,
    BK_LETTER,
    BK_RETURN
  } byte_kind_e;

  typedef struct packed {
    byte_kind_e kind;
    cmd_e       code;
    logic [3:0] digit;
  } byte_class_t;

  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_NINE = 8'h39;
  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_LF   = 8'h0A;
  localparam logic [7:0] CH_FREQ = 8'h66;
  localparam logic [7:0] CH_PHS  = 8'h70;
  localparam logic [7:0] CH_AMP  = 8'h61;

  function automatic byte_class_t classify(input logic [7:0] b);
    byte_class_t c;
    logic [7:0]  off;
    off     = b - CH_ZERO;
    c.kind  = BK_OTHER;
    c.code  = CMD_NONE;
    c.digit = off[3:0];
    if (b >= CH_ZERO && b <= CH_NINE) c.kind = BK_DIGIT;
    else begin
      case (b)
        CH_FREQ: begin c.kind = BK_LETTER; c.code = CMD_FREQ;  end
        CH_PHS:  begin c.kind = BK_LETTER; c.code = CMD_PHASE; end
        CH_AMP:  begin c.kind = BK_LETTER; c.code = CMD_AMPL;  end
        CH_CR:   c.kind = BK_RETURN;
        default: c.kind = BK_OTHER;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/dcp_accum.sv
module dcp_accum #(
  parameter int VALUE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dig_en,
  input  logic [3:0]         digit,
  input  logic               restart,
  output logic [VALUE_W-1:0] value
);
  logic               fresh_q;
  logic [VALUE_W-1:0] acc_q;
  logic [VALUE_W-1:0] times_ten;

  // x*10 = (x<<3) + (x<<1), truncated to VALUE_W bits
  assign times_ten = (acc_q << 3) + (acc_q << 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      fresh_q <= 1'b1;
    end else if (dig_en) begin
      acc_q   <= fresh_q ? VALUE_W'(digit) : times_ten + VALUE_W'(digit);
      fresh_q <= 1'b0;
    end else if (restart) begin
      fresh_q <= 1'b1;
    end
  end

  assign value = acc_q;

  // R6/R11: without a digit the held number never moves
  p_value_held_r11: assert property (@(posedge clk) disable iff (rst)
    !dig_en |=> $stable(value));
endmodule

// File: rtl/dcp_echo.sv
module dcp_echo (
  input  logic       clk,
  input  logic       rst,
  input  logic       echo_en,
  input  logic [7:0] echo_byte,
  input  logic       echo_cr,
  input  logic       tx_busy,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  import dcp_pkg::*;

  logic lf_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      lf_pend_q <= 1'b0;
    end else if (echo_en) begin
      tx_valid  <= 1'b1;
      tx_byte   <= echo_byte;
      lf_pend_q <= lf_pend_q | echo_cr;
    end else if (lf_pend_q && !tx_busy && !tx_valid) begin
      tx_valid  <= 1'b1;
      tx_byte   <= CH_LF;
      lf_pend_q <= 1'b0;
    end else begin
      tx_valid  <= 1'b0;
    end
  end

  p_echo_next_r5: assert property (@(posedge clk) disable iff (rst)
    echo_en |=> tx_valid && tx_byte == $past(echo_byte));

  p_lf_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_byte == CH_LF && !$past(echo_en)) |-> !$past(tx_busy));
endmodule

// File: rtl/dcp_cmd_hold.sv
module dcp_cmd_hold #(
  parameter int VALUE_W = 32,
  parameter int AMP_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  dcp_pkg::cmd_e      load_code,
  input  logic [VALUE_W-1:0] acc_value,
  input  logic               ack,
  output logic [1:0]         code,
  output logic [VALUE_W-1:0] value
);
  import dcp_pkg::*;

  cmd_e code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CMD_NONE;
      value  <= '0;
    end else if (load) begin
      code_q <= load_code;
      value  <= (load_code == CMD_AMPL) ? VALUE_W'(acc_value[AMP_W-1:0]) : acc_value;
    end else if (ack) begin
      code_q <= CMD_NONE;
    end
  end

  assign code = code_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (code != 2'd0 && !ack && !load) |=> code == $past(code) && $stable(value));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && !load) |=> code == 2'd0);

  p_amp_field_r9: assert property (@(posedge clk) disable iff (rst)
    (load && load_code == CMD_AMPL) |=> value[VALUE_W-1:AMP_W] == '0);
endmodule

// File: rtl/dec_cmd_parser.sv
module dec_cmd_parser #(
  parameter int VALUE_W = 32,
  parameter int AMP_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               tx_busy,
  output logic               tx_valid,
  output logic [7:0]         tx_byte,
  output logic [1:0]         cmd_code,
  output logic [VALUE_W-1:0] cmd_value,
  input  logic               cmd_ack
);
  import dcp_pkg::*;

  byte_class_t        cls;
  logic               is_digit, is_letter, is_cr, known;
  logic [VALUE_W-1:0] acc_value;

  always_comb begin
    cls       = classify(rx_byte);
    is_digit  = rx_valid && cls.kind == BK_DIGIT;
    is_letter = rx_valid && cls.kind == BK_LETTER;
    is_cr     = rx_valid && cls.kind == BK_RETURN;
    known     = is_digit || is_letter || is_cr;
  end

  dcp_accum #(.VALUE_W(VALUE_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .dig_en  (is_digit),
    .digit   (cls.digit),
    .restart (is_letter || is_cr),
    .value   (acc_value)
  );

  dcp_echo u_echo (
    .clk       (clk),
    .rst       (rst),
    .echo_en   (known),
    .echo_byte (rx_byte),
    .echo_cr   (is_cr),
    .tx_busy   (tx_busy),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  dcp_cmd_hold #(.VALUE_W(VALUE_W), .AMP_W(AMP_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (is_letter),
    .load_code (cls.code),
    .acc_value (acc_value),
    .ack       (cmd_ack),
    .code      (cmd_code),
    .value     (cmd_value)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_code == 2'd0 && !tx_valid));

  p_no_echo_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !known && !u_echo.lf_pend_q) |=> !tx_valid);

  p_cr_no_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (is_cr && cmd_code == 2'd0) |=> cmd_code == 2'd0);
endmodule

// File: tb/tb_dec_cmd_parser.sv
module tb_dec_cmd_parser;
  localparam int VW   = 32;
  localparam int AW   = 16;
  localparam int BUSY = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          tx_busy;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic [1:0]    cmd_code;
  logic [VW-1:0] cmd_value;
  logic          cmd_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  logic busy_prev = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  dec_cmd_parser #(.VALUE_W(VW), .AMP_W(AW)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_busy(tx_busy), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .cmd_code(cmd_code), .cmd_value(cmd_value), .cmd_ack(cmd_ack));

  // transmitter model: busy for BUSY cycles after each send
  always @(posedge clk) begin
    if (rst) busy_cnt <= 0;
    else if (tx_valid) busy_cnt <= BUSY;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign tx_busy = (busy_cnt != 0);

  // monitor: pop and compare echoed characters
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5/R6: unexpected tx byte %h, expected none", tx_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_byte !== e) begin
          errors++;
          $display("FAIL R5/R7: tx byte %h, expected %h", tx_byte, e);
        end
      end
      if (tx_byte == 8'h0A) begin
        checks++;
        if (busy_prev !== 1'b0) begin
          errors++;
          $display("FAIL R7: LF sent with busy=%b, expected 0", busy_prev);
        end
      end
    end
    busy_prev <= tx_busy;
  end

  function automatic bit known(input logic [7:0] b);
    return (b >= 8'h30 && b <= 8'h39) || b == 8'h66 || b == 8'h70 ||
           b == 8'h61 || b == 8'h0D;
  endfunction

  task automatic send_byte(input logic [7:0] b, input int gap, input bit ack_too);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    cmd_ack  = ack_too;
    if (known(b)) exp_q.push_back(b);
    if (b == 8'h0D) exp_q.push_back(8'h0A);
    @(negedge clk);
    rx_valid = 1'b0;
    cmd_ack  = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_str(input string s, input int gap);
    for (int i = 0; i < s.len(); i++) send_byte(s[i], gap, 1'b0);
  endtask

  // called right after a letter: send_byte ended one negedge after rx_valid
  task automatic check_cmd(input logic [1:0] c, input logic [VW-1:0] v, input string tag);
    checks++;
    if (cmd_code !== c || cmd_value !== v) begin
      errors++;
      $display("FAIL %s: code/value %0d/%0d, expected %0d/%0d", tag, cmd_code, cmd_value, c, v);
    end
  endtask

  task automatic do_ack();
    @(negedge clk); cmd_ack = 1'b1;
    @(negedge clk); cmd_ack = 1'b0;
    checks++;
    if (cmd_code !== 2'd0) begin
      errors++;
      $display("FAIL R8: code after ack %0d, expected 0", cmd_code);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1
    if (cmd_code !== 2'd0 || tx_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: code %0d tx_valid %b, expected 0 0", cmd_code, tx_valid);
    end
    // R1/R11: letter with no digits right after reset carries 0
    send_byte("p", 0, 1'b0);
    check_cmd(2'd2, 0, "R1");
    do_ack();

    // R2 R3: multi-digit number and frequency letter
    send_str("123", 8);
    send_byte("f", 0, 1'b0);
    check_cmd(2'd1, 123, "R2");
    repeat (6) @(negedge clk);
    check_cmd(2'd1, 123, "R8 hold");
    do_ack();

    // R11: bare letter reuses last number
    send_byte("p", 0, 1'b0);
    check_cmd(2'd2, 123, "R11");
    do_ack();

    // R3: letter clears count, next digits start fresh
    send_str("6", 8);
    send_byte("a", 0, 1'b0);
    check_cmd(2'd3, 6, "R3");
    do_ack();

    // R4 R7: CR clears count, no command, LF follows once idle
    send_str("45", 8);
    send_byte(8'h0D, 0, 1'b0);
    check_cmd(2'd0, 6, "R4 no cmd");
    repeat (12) @(negedge clk);
    send_byte("7", 8, 1'b0);
    send_byte("f", 0, 1'b0);
    check_cmd(2'd1, 7, "R4 restart");
    do_ack();

    // R6: unrecognised bytes dropped
    send_str("1x2Z", 8);
    send_byte("f", 0, 1'b0);
    check_cmd(2'd1, 12, "R6");
    do_ack();

    // R9: amplitude keeps low 16 bits (70000 mod 65536 = 4464)
    send_str("70000", 8);
    send_byte("a", 0, 1'b0);
    check_cmd(2'd3, 4464, "R9");
    do_ack();

    // R10: wrap modulo 2^32 (4294967301 -> 5)
    send_str("4294967301", 8);
    send_byte("f", 0, 1'b0);
    check_cmd(2'd1, 5, "R10");
    do_ack();

    // R12: new letter replaces pending one, wins over same-cycle ack
    send_str("9f", 8);
    check_cmd(2'd1, 9, "R12 first");
    send_str("8", 8);
    send_byte("p", 0, 1'b1);
    check_cmd(2'd2, 8, "R12 replace");
    do_ack();

    // R5: back-to-back bytes echoed while transmitter busy
    send_str("77", 0);
    send_byte("f", 0, 1'b0);
    check_cmd(2'd1, 77, "R5");
    do_ack();

    // R7: CR while busy, LF deferred
    send_byte(8'h0D, 0, 1'b0);
    repeat (15) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5/R7: %0d echoes missing, expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule